// File: doc/BRIEF.md
# USB IN Endpoint Responder

This block holds the device-side state of one IN endpoint and picks the answer to every IN token seen on the bus. The answer is one of three: send the oldest complete packet waiting in the endpoint's transmit buffer, reply with a NAK handshake, or send a zero-length data packet. The endpoint's settings include an enable bit, a NAK-mode flag and a type selector, where isochronous endpoints are treated as periodic. NAK mode and the endpoint type take priority over any data already waiting in the buffer.

A writer loads the endpoint a whole packet at a time. It first asks for room by giving the packet length in 32-bit words. If the request is granted, it streams exactly that many words. The block keeps a count of free words and raises a buffer-empty flag, so the writer can poll the count or wait for the flag. Space is reserved when a request is granted and given back only once the last word of that packet has gone out. Set-NAK and clear-NAK commands switch NAK mode on and off, and a sticky flag reports when NAK mode has actually taken effect.

Top module: `inep_responder`

## Requirements
- R1: After reset the endpoint is disabled and not in NAK mode. The free count is the full depth (64 words), `irq_txfe` is 1, and `irq_nak_eff`, `rsp_valid`, `tx_valid`, `wr_ack` and `wr_rej` are 0.
- R2: Each token sampled while no packet is being sent gets `rsp_valid` for one cycle, one cycle later. If the endpoint is enabled, not in NAK mode and holds a complete packet, `rsp_kind` is 0 (data) and `rsp_len` is the packet length. The packet's words then appear on `tx_data` with `tx_valid` on the next `rsp_len` cycles, in written order, with `tx_last` and `xfer_cmpl` on the final word. A queued zero-length packet gives `xfer_cmpl` together with the response.
- R3: In NAK mode a token on a non-isochronous endpoint gets `rsp_kind` 1 (NAK), even with complete packets waiting. Those packets stay queued and their space stays reserved.
- R4: In NAK mode a token on an isochronous endpoint gets `rsp_kind` 2 (zero-length packet), even with complete packets waiting.
- R5: A token arriving when the endpoint is disabled, or when no complete packet is queued, gets kind 1 on a non-isochronous endpoint and kind 2 on an isochronous one.
- R6: `irq_nak_eff` rises one cycle after NAK mode is in force and no packet is being sent, and it then holds. A clear-NAK pulse leaves NAK mode and drops `irq_nak_eff` in the next cycle. Clear wins over set.
- R7: A write request with non-zero length is granted (`wr_ack`, one cycle later) only if the length does not exceed the free count. Otherwise `wr_rej` is given and the free count is unchanged.
- R8: A zero-length write request is granted whatever the free count, including zero.
- R9: A non-isochronous endpoint accepts several packets while space allows and sends them in the order they were written.
- R10: An isochronous endpoint accepts one packet. Further requests are refused until `xfer_cmpl` has been raised for that packet.
- R11: The free count drops by the packet length in the cycle `wr_ack` appears. It rises by the packet length in the cycle `tx_last` appears. `irq_txfe` is 1 exactly when the free count equals the depth.
- R12: A write request on a disabled endpoint gives `wr_rej` and `wr_err`. A data word with no granted packet open gives `wr_err` and is dropped.
- R13: A token that arrives while a packet is being sent gets no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Loads the endpoint control word |
| cfg_enable | input | 1 | Endpoint enable value loaded by cfg_wr |
| cfg_iso | input | 1 | 1 = isochronous (periodic) endpoint |
| nak_set | input | 1 | Enter NAK mode |
| nak_clr | input | 1 | Leave NAK mode and clear the NAK-effective flag |
| wr_req | input | 1 | Request room for one packet |
| wr_len | input | 7 | Packet length in 32-bit words (0..64) |
| wr_dvalid | input | 1 | Data word strobe for the open packet |
| wr_data | input | 32 | Data word |
| wr_ack | output | 1 | Request granted |
| wr_rej | output | 1 | Request refused |
| wr_err | output | 1 | Write while disabled or stray data word |
| tok_in | input | 1 | IN token strobe |
| rsp_valid | output | 1 | Token answer is valid |
| rsp_kind | output | 2 | 0 data, 1 NAK, 2 zero-length packet |
| rsp_len | output | 7 | Length of the data packet being sent |
| tx_valid | output | 1 | Outgoing data word valid |
| tx_data | output | 32 | Outgoing data word |
| tx_last | output | 1 | Final word of the packet |
| xfer_cmpl | output | 1 | Packet fully sent |
| free_words | output | 7 | Free space in words |
| irq_txfe | output | 1 | Transmit buffer empty |
| irq_nak_eff | output | 1 | NAK mode in effect |

## Verification
The bench sends tokens while full packets are queued and NAK mode is set. A design that let queued data win would send the packet instead of a NAK or a zero-length reply, and would release its space. It fills the buffer to exactly zero and then asks for one more word and for an empty packet. An off-by-one in the room check would grant the one-word request, and a check that ignored length zero would refuse the empty packet. It asks for a second packet on a periodic endpoint before and after the first one completes, which catches both a missing re-arm and a missing refusal. It also issues a token in the middle of a packet being sent, which a design without the busy guard would answer, and it checks that space comes back only together with the last word rather than at the start of sending.

// File: rtl/inep_pkg.sv
package inep_pkg;
  typedef enum logic [1:0] {
    RSP_DATA = 2'd0,
    RSP_NAK  = 2'd1,
    RSP_ZLP  = 2'd2
  } rsp_kind_e;
endpackage

// File: rtl/inep_txmem.sv
// Word storage of the transmit buffer: one write port, one registered read port.
module inep_txmem #(
  parameter int DW = 32,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int WORDS = 1 << AW;

  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/inep_desc_q.sv
// Small queue of complete-packet lengths, oldest first.
module inep_desc_q #(
  parameter int LW  = 7,
  parameter int QAW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [LW-1:0] push_len,
  input  logic          pop,
  output logic [LW-1:0] head_len,
  output logic          empty,
  output logic          full
);
  localparam int SLOTS = 1 << QAW;
  localparam int CW    = QAW + 1;

  logic [LW-1:0]  slot [SLOTS];
  logic [QAW-1:0] wp_q, rp_q;
  logic [CW-1:0]  cnt_q;
  logic           push_ok, pop_ok;

  assign empty    = (cnt_q == '0);
  assign full     = (cnt_q == CW'(SLOTS));
  assign push_ok  = push && !full;
  assign pop_ok   = pop && !empty;
  assign head_len = slot[rp_q];

  always_ff @(posedge clk) begin
    if (push_ok) slot[wp_q] <= push_len;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) wp_q <= wp_q + 1'b1;
      if (pop_ok)  rp_q <= rp_q + 1'b1;
      cnt_q <= cnt_q + CW'(push_ok) - CW'(pop_ok);
    end
  end

  AST_DESC_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) push |-> !full); // R9
  AST_DESC_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst) pop |-> !empty); // R2
endmodule

// File: rtl/inep_wrside.sv
// Packet admission and buffer write control.
module inep_wrside #(
  parameter int AW = 6,
  parameter int LW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ep_en,
  input  logic          ep_iso,
  input  logic          wr_req,
  input  logic [LW-1:0] wr_len,
  input  logic          wr_dvalid,
  input  logic [LW-1:0] free_words,
  input  logic          desc_full,
  input  logic          xfer_done,
  output logic          accept,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic          desc_push,
  output logic [LW-1:0] desc_len,
  output logic          wr_ack,
  output logic          wr_rej,
  output logic          wr_err
);
  logic          open_q, armed_q;
  logic [LW-1:0] rem_q, len_q;
  logic [AW-1:0] wptr_q;
  logic          ack_q, rej_q, err_q;
  logic          room, period_ok, take, done_word;

  assign room      = (wr_len <= free_words);
  assign period_ok = !ep_iso || armed_q;
  assign accept    = wr_req && ep_en && !open_q && !desc_full && room && period_ok;
  assign take      = wr_dvalid && open_q;
  assign done_word = take && (rem_q == LW'(1));

  assign mem_we    = take;
  assign mem_waddr = wptr_q;
  assign desc_push = (accept && (wr_len == '0)) || done_word;
  assign desc_len  = done_word ? len_q : '0;

  assign wr_ack = ack_q;
  assign wr_rej = rej_q;
  assign wr_err = err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q  <= 1'b0;
      armed_q <= 1'b1;
      rem_q   <= '0;
      len_q   <= '0;
      wptr_q  <= '0;
      ack_q   <= 1'b0;
      rej_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      ack_q <= accept;
      rej_q <= wr_req && !accept;
      err_q <= (wr_req && !ep_en) || (wr_dvalid && !open_q);
      if (accept && (wr_len != '0)) begin
        open_q <= 1'b1;
        rem_q  <= wr_len;
        len_q  <= wr_len;
      end
      if (take) begin
        wptr_q <= wptr_q + 1'b1;
        rem_q  <= rem_q - 1'b1;
        if (done_word) open_q <= 1'b0;
      end
      if (accept && ep_iso) armed_q <= 1'b0;
      else if (xfer_done)   armed_q <= 1'b1;
    end
  end

  AST_NO_ROOM_NO_ACK: assert property (@(posedge clk) disable iff (rst)
    (wr_req && (wr_len > free_words)) |=> !wr_ack); // R7
  AST_DISABLED_REFUSE: assert property (@(posedge clk) disable iff (rst)
    (wr_req && !ep_en) |=> (wr_rej && wr_err)); // R12
  AST_ISO_ONE_FRAME: assert property (@(posedge clk) disable iff (rst)
    (wr_req && ep_iso && !armed_q) |=> !wr_ack); // R10
endmodule

// File: rtl/inep_responder.sv
module inep_responder #(
  parameter int DW  = 32,
  parameter int AW  = 6,
  parameter int QAW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_wr,
  input  logic          cfg_enable,
  input  logic          cfg_iso,
  input  logic          nak_set,
  input  logic          nak_clr,
  input  logic          wr_req,
  input  logic [AW:0]   wr_len,
  input  logic          wr_dvalid,
  input  logic [DW-1:0] wr_data,
  output logic          wr_ack,
  output logic          wr_rej,
  output logic          wr_err,
  input  logic          tok_in,
  output logic          rsp_valid,
  output logic [1:0]    rsp_kind,
  output logic [AW:0]   rsp_len,
  output logic          tx_valid,
  output logic [DW-1:0] tx_data,
  output logic          tx_last,
  output logic          xfer_cmpl,
  output logic [AW:0]   free_words,
  output logic          irq_txfe,
  output logic          irq_nak_eff
);
  import inep_pkg::*;

  localparam int DEPTH = 1 << AW;
  localparam int LW    = AW + 1;

  logic          ep_en_q, ep_iso_q, nak_q, nak_eff_q;
  logic [LW-1:0] free_q, free_d;
  logic          txfe_q;

  logic          accept, mem_we, desc_push, desc_full, desc_empty, desc_pop;
  logic [AW-1:0] mem_waddr;
  logic [LW-1:0] desc_len, head_len;

  logic          busy_q, tx_valid_q, tx_last_q, cmpl_q, rsp_valid_q;
  logic [LW-1:0] tx_rem_q, tx_len_q, rsp_len_q;
  logic [AW-1:0] rptr_q;
  rsp_kind_e     rsp_kind_q;
  logic          tok_seen, pkt_go, rel, cmpl_now;

  // Endpoint control word
  always_ff @(posedge clk) begin
    if (rst) begin
      ep_en_q  <= 1'b0;
      ep_iso_q <= 1'b0;
    end else if (cfg_wr) begin
      ep_en_q  <= cfg_enable;
      ep_iso_q <= cfg_iso;
    end
  end

  // NAK mode and its effective flag; clear has priority
  always_ff @(posedge clk) begin
    if (rst) begin
      nak_q     <= 1'b0;
      nak_eff_q <= 1'b0;
    end else if (nak_clr) begin
      nak_q     <= 1'b0;
      nak_eff_q <= 1'b0;
    end else begin
      if (nak_set) nak_q <= 1'b1;
      if (nak_q && !busy_q) nak_eff_q <= 1'b1;
    end
  end

  inep_wrside #(.AW(AW), .LW(LW)) u_wr (
    .clk        (clk),
    .rst        (rst),
    .ep_en      (ep_en_q),
    .ep_iso     (ep_iso_q),
    .wr_req     (wr_req),
    .wr_len     (wr_len),
    .wr_dvalid  (wr_dvalid),
    .free_words (free_q),
    .desc_full  (desc_full),
    .xfer_done  (cmpl_now),
    .accept     (accept),
    .mem_we     (mem_we),
    .mem_waddr  (mem_waddr),
    .desc_push  (desc_push),
    .desc_len   (desc_len),
    .wr_ack     (wr_ack),
    .wr_rej     (wr_rej),
    .wr_err     (wr_err)
  );

  inep_desc_q #(.LW(LW), .QAW(QAW)) u_desc (
    .clk      (clk),
    .rst      (rst),
    .push     (desc_push),
    .push_len (desc_len),
    .pop      (desc_pop),
    .head_len (head_len),
    .empty    (desc_empty),
    .full     (desc_full)
  );

  inep_txmem #(.DW(DW), .AW(AW)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (wr_data),
    .re    (busy_q),
    .raddr (rptr_q),
    .rdata (tx_data)
  );

  // Token decision: NAK mode and type override queued data
  assign tok_seen = tok_in && !busy_q;
  assign pkt_go   = tok_seen && ep_en_q && !nak_q && !desc_empty;
  assign desc_pop = pkt_go;
  assign rel      = busy_q && (tx_rem_q == LW'(1));
  assign cmpl_now = rel || (pkt_go && (head_len == '0));

  always_comb begin
    free_d = free_q;
    if (accept) free_d = free_d - wr_len;
    if (rel)    free_d = free_d + tx_len_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q      <= 1'b0;
      tx_rem_q    <= '0;
      tx_len_q    <= '0;
      rptr_q      <= '0;
      tx_valid_q  <= 1'b0;
      tx_last_q   <= 1'b0;
      cmpl_q      <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_kind_q  <= RSP_NAK;
      rsp_len_q   <= '0;
      free_q      <= LW'(DEPTH);
      txfe_q      <= 1'b1;
    end else begin
      rsp_valid_q <= tok_seen;
      if (tok_seen) begin
        rsp_kind_q <= pkt_go ? RSP_DATA : (ep_iso_q ? RSP_ZLP : RSP_NAK);
        rsp_len_q  <= pkt_go ? head_len : '0;
      end
      if (pkt_go && (head_len != '0)) begin
        busy_q   <= 1'b1;
        tx_rem_q <= head_len;
        tx_len_q <= head_len;
      end else if (busy_q) begin
        rptr_q   <= rptr_q + 1'b1;
        tx_rem_q <= tx_rem_q - 1'b1;
        if (rel) busy_q <= 1'b0;
      end
      tx_valid_q <= busy_q;
      tx_last_q  <= rel;
      cmpl_q     <= cmpl_now;
      free_q     <= free_d;
      txfe_q     <= (free_d == LW'(DEPTH));
    end
  end

  assign rsp_valid   = rsp_valid_q;
  assign rsp_kind    = rsp_kind_q;
  assign rsp_len     = rsp_len_q;
  assign tx_valid    = tx_valid_q;
  assign tx_last     = tx_last_q;
  assign xfer_cmpl   = cmpl_q;
  assign free_words  = free_q;
  assign irq_txfe    = txfe_q;
  assign irq_nak_eff = nak_eff_q;

  AST_NAK_BLOCKS_DATA: assert property (@(posedge clk) disable iff (rst)
    (tok_in && !busy_q && nak_q) |=> (rsp_valid && (rsp_kind != 2'd0))); // R3
  AST_ISO_ZLP_IN_NAK: assert property (@(posedge clk) disable iff (rst)
    (tok_in && !busy_q && nak_q && ep_iso_q) |=> (rsp_kind == 2'd2)); // R4
  AST_BUSY_IGNORES_TOKEN: assert property (@(posedge clk) disable iff (rst)
    (tok_in && busy_q) |=> !rsp_valid); // R13
  AST_NAK_EFF_IMPLIES_MODE: assert property (@(posedge clk) disable iff (rst)
    irq_nak_eff |-> nak_q); // R6
  AST_FREE_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    free_words <= LW'(DEPTH)); // R11
  AST_LAST_HAS_CMPL: assert property (@(posedge clk) disable iff (rst)
    tx_last |-> (xfer_cmpl && tx_valid)); // R2
endmodule

// File: tb/inep_responder_tb.sv
`timescale 1ns/1ps
module inep_responder_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_wr, cfg_enable, cfg_iso, nak_set, nak_clr;
  logic        wr_req, wr_dvalid, tok_in;
  logic [6:0]  wr_len;
  logic [31:0] wr_data;
  logic        wr_ack, wr_rej, wr_err;
  logic        rsp_valid, tx_valid, tx_last, xfer_cmpl, irq_txfe, irq_nak_eff;
  logic [1:0]  rsp_kind;
  logic [6:0]  rsp_len, free_words;
  logic [31:0] tx_data;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  int tag = 1;
  int q_tag [32];
  int q_len [32];
  int q_head = 0;
  int q_tail = 0;

  always #2.5 clk = ~clk;

  inep_responder u_dut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_enable(cfg_enable), .cfg_iso(cfg_iso),
    .nak_set(nak_set), .nak_clr(nak_clr), .wr_req(wr_req), .wr_len(wr_len),
    .wr_dvalid(wr_dvalid), .wr_data(wr_data), .wr_ack(wr_ack), .wr_rej(wr_rej),
    .wr_err(wr_err), .tok_in(tok_in), .rsp_valid(rsp_valid), .rsp_kind(rsp_kind),
    .rsp_len(rsp_len), .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
    .xfer_cmpl(xfer_cmpl), .free_words(free_words), .irq_txfe(irq_txfe),
    .irq_nak_eff(irq_nak_eff)
  );

  // Vector: op[17:16] (0 write, 1 token), len[15:9], exp[8:7] (ack or kind), free[6:0]
  localparam logic [17:0] VEC [12] = '{
    {2'd0, 7'd16, 2'd1, 7'd48},  // R9
    {2'd0, 7'd40, 2'd1, 7'd8},   // R9
    {2'd0, 7'd9,  2'd0, 7'd8},   // R7
    {2'd0, 7'd8,  2'd1, 7'd0},   // R7 exact fit
    {2'd0, 7'd0,  2'd1, 7'd0},   // R8
    {2'd1, 7'd16, 2'd0, 7'd16},  // R2
    {2'd1, 7'd40, 2'd0, 7'd56},  // R9 order
    {2'd1, 7'd8,  2'd0, 7'd64},  // R11
    {2'd1, 7'd0,  2'd0, 7'd64},  // R2 zero-length
    {2'd1, 7'd0,  2'd1, 7'd64},  // R5
    {2'd0, 7'd64, 2'd1, 7'd0},   // R11
    {2'd0, 7'd1,  2'd0, 7'd0}    // R7
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_cfg(input logic en, input logic iso);
    @(negedge clk); cfg_wr = 1'b1; cfg_enable = en; cfg_iso = iso;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic do_write(input int len, input bit exp_ack, input string req);
    @(negedge clk); wr_req = 1'b1; wr_len = 7'(len);
    @(negedge clk); wr_req = 1'b0;
    chk(wr_ack == exp_ack, req, int'(wr_ack), int'(exp_ack));
    if (wr_ack) begin
      for (int i = 0; i < len; i++) begin
        wr_dvalid = 1'b1; wr_data = {16'(tag), 16'(i)};
        @(negedge clk);
      end
      wr_dvalid = 1'b0;
      q_tag[q_tail % 32] = tag; q_len[q_tail % 32] = len; q_tail++;
      tag++;
    end
  endtask

  task automatic check_words(input int t, input int len, input int from, input string req);
    for (int i = from; i < len; i++) begin
      @(negedge clk);
      chk(tx_valid && tx_data == {16'(t), 16'(i)}, req, int'(tx_data[15:0]), i);
      chk(tx_last == (i == len - 1), req, int'(tx_last), int'(i == len - 1));
      if (i == len - 1) chk(xfer_cmpl == 1'b1, req, int'(xfer_cmpl), 1);
    end
  endtask

  task automatic do_token(input int exp_kind, input int exp_len, input string req);
    int t, l;
    @(negedge clk); tok_in = 1'b1;
    @(negedge clk); tok_in = 1'b0;
    chk(rsp_valid == 1'b1, req, int'(rsp_valid), 1);
    chk(int'(rsp_kind) == exp_kind, req, int'(rsp_kind), exp_kind);
    chk(int'(rsp_len) == exp_len, req, int'(rsp_len), exp_len);
    if (exp_kind == 0) begin
      t = q_tag[q_head % 32]; l = q_len[q_head % 32]; q_head++;
      if (l == 0) chk(xfer_cmpl == 1'b1, req, int'(xfer_cmpl), 1);
      check_words(t, l, 0, req);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; cfg_wr = 0; cfg_enable = 0; cfg_iso = 0; nak_set = 0; nak_clr = 0;
    wr_req = 0; wr_len = '0; wr_dvalid = 0; wr_data = '0; tok_in = 0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1 reset state
    chk(free_words == 7'd64, "R1", int'(free_words), 64);
    chk(irq_txfe == 1'b1, "R1", int'(irq_txfe), 1);
    chk(!irq_nak_eff && !rsp_valid && !tx_valid, "R1", int'(irq_nak_eff), 0);
    chk(!wr_ack && !wr_rej, "R1", int'(wr_ack), 0);

    // R12 disabled endpoint
    @(negedge clk); wr_req = 1'b1; wr_len = 7'd4;
    @(negedge clk); wr_req = 1'b0;
    chk(wr_rej && wr_err && !wr_ack, "R12", int'(wr_err), 1);
    wr_dvalid = 1'b1; wr_data = 32'hDEAD;
    @(negedge clk); wr_dvalid = 1'b0;
    chk(wr_err == 1'b1, "R12", int'(wr_err), 1);
    chk(free_words == 7'd64, "R12", int'(free_words), 64);
    do_token(1, 0, "R5");

    pulse_cfg(1'b1, 1'b0);
    for (int k = 0; k < 12; k++) begin
      logic [17:0] v;
      v = VEC[k];
      if (v[17:16] == 2'd0) do_write(int'(v[15:9]), v[7], "R7");
      else do_token(int'(v[8:7]), int'(v[8:7]) == 0 ? int'(v[15:9]) : 0, "R2");
      chk(free_words == v[6:0], "R11", int'(free_words), int'(v[6:0]));
      if (k == 0) chk(irq_txfe == 1'b0, "R11", int'(irq_txfe), 0);
    end

    // R3 / R6 NAK mode with a full packet queued
    @(negedge clk); nak_set = 1'b1;
    @(negedge clk); nak_set = 1'b0;
    @(negedge clk);
    chk(irq_nak_eff == 1'b1, "R6", int'(irq_nak_eff), 1);
    do_token(1, 0, "R3");
    chk(free_words == 7'd0, "R3", int'(free_words), 0);
    chk(irq_nak_eff == 1'b1, "R6", int'(irq_nak_eff), 1);
    @(negedge clk); nak_clr = 1'b1;
    @(negedge clk); nak_clr = 1'b0;
    chk(irq_nak_eff == 1'b0, "R6", int'(irq_nak_eff), 0);
    do_token(0, 64, "R2");
    chk(free_words == 7'd64 && irq_txfe, "R11", int'(free_words), 64);

    // R13 token during a packet being sent
    do_write(4, 1'b1, "R9");
    @(negedge clk); tok_in = 1'b1;
    @(negedge clk);
    chk(rsp_valid && rsp_kind == 2'd0 && rsp_len == 7'd4, "R13", int'(rsp_kind), 0);
    @(negedge clk); tok_in = 1'b0;
    chk(rsp_valid == 1'b0, "R13", int'(rsp_valid), 0);
    chk(tx_valid && tx_data == {16'(q_tag[q_head % 32]), 16'd0}, "R13", int'(tx_data[15:0]), 0);
    check_words(q_tag[q_head % 32], 4, 1, "R13");
    q_head++;
    chk(free_words == 7'd64, "R11", int'(free_words), 64);

    // Isochronous endpoint
    pulse_cfg(1'b1, 1'b1);
    do_token(2, 0, "R5");
    do_write(4, 1'b1, "R10");
    do_write(4, 1'b0, "R10");
    @(negedge clk); nak_set = 1'b1;
    @(negedge clk); nak_set = 1'b0;
    do_token(2, 0, "R4");
    chk(free_words == 7'd60, "R4", int'(free_words), 60);
    @(negedge clk); nak_clr = 1'b1;
    @(negedge clk); nak_clr = 1'b0;
    do_token(0, 4, "R2");
    do_write(4, 1'b1, "R10");
    do_token(0, 4, "R10");

    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule